// File: doc/BRIEF.md
# Serial Display Link Power-Up Sequencer

This controller brings a serial display link transmitter up in a fixed, timed order and takes it down again. A requester holds `link_req` high to ask for the link and low to release it. From the off state, a rising request first turns on the global display controller. Next it enables the link interface. It then turns on the transmitter regulator and loads its fixed trim values. After two timed waits it turns on the bias block and then the clock-lane driver. Last, it enables the data-lane drivers, with the number of lanes chosen by the pixel depth. Teardown runs in the opposite order against the global enable: the link interface is dropped first and the global controller one cycle later. The analog enables are left as they are during teardown.

The waits are counted in clock cycles. Each wait lasts `2*CLK_PER_US` cycles, so `CLK_PER_US` must be set to the number of clock cycles in one microsecond. While a sequence runs, `seq_busy` is high. `seq_done` pulses for one cycle when the last step of either sequence is applied. The request is a level input. Changes to it during a running sequence have no effect until that sequence ends.

The state machine has these states: IDLE_OFF, GLB_UP, IF_UP, LDO_WAIT, BIAS_WAIT, CLKDRV_UP, LINK_ON and IF_DOWN. Its transitions are:
- IDLE_OFF→GLB_UP when the request is high.
- GLB_UP→IF_UP, IF_UP→LDO_WAIT and CLKDRV_UP→LINK_ON, each unconditionally.
- LDO_WAIT→BIAS_WAIT and BIAS_WAIT→CLKDRV_UP, each on wait expiry.
- LINK_ON→IF_DOWN when the request is low.
- IF_DOWN→IDLE_OFF, unconditionally.

Top module: `lvds_pwr_seq`

## Requirements
- R1: After reset, every enable output, every trim output, `data_drv_en`, `seq_busy` and `seq_done` are 0.
- R2: When the request is seen high in the off state, `glb_en` and `seq_busy` rise at that clock edge. `link_if_en` rises one edge later. One edge after that, `ldo_en` rises, and the trims take current=2, voltage=3 and pre-drive=2 (3-bit fields) at the same edge.
- R3: `bias_en` rises exactly `2*CLK_PER_US` clock edges after the edge where `ldo_en` was applied.
- R4: `clk_drv_en` rises exactly `2*CLK_PER_US` clock edges after the edge where `bias_en` rose.
- R5: One edge after `clk_drv_en` rises, `data_drv_en` is loaded. It takes 4'b0111 (lanes 0..2, bit i = lane i) when `depth18` is 1 and 4'b1111 when `depth18` is 0, with `depth18` sampled at that edge.
- R6: `seq_done` is high for exactly one cycle, at the final step of bring-up and at the final step of teardown. `seq_busy` is high from the first step of a sequence until that cycle and is low whenever `seq_done` is high.
- R7: When the request is seen low in the on state, `link_if_en` falls and `seq_busy` rises at that edge. `glb_en` falls one edge later.
- R8: Teardown leaves `ldo_en`, `bias_en`, `clk_drv_en`, `data_drv_en` and the trims at their values.
- R9: On a later bring-up, the edge that applies `ldo_en` also clears `bias_en`, `clk_drv_en` and `data_drv_en` to 0 before they are sequenced up again.
- R10: Request changes while `seq_busy` is high do not alter any output until the sequence completes. After that, the request level present at the next edge decides.
- R11: A request held high in the on state, or held low in the off state, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_req | input | 1 | Level request: 1 = link up, 0 = link down |
| depth18 | input | 1 | 1 = 18-bit pixels (three lanes), 0 = 24-bit (four lanes) |
| seq_busy | output | 1 | A sequence is in progress |
| seq_done | output | 1 | One-cycle pulse at the final step of a sequence |
| glb_en | output | 1 | Global display controller enable |
| link_if_en | output | 1 | Link interface enable |
| ldo_en | output | 1 | Transmitter regulator enable |
| cur_trim | output | 3 | Current trim field |
| volt_trim | output | 3 | Voltage trim field |
| pdrv_trim | output | 3 | Pre-drive trim field |
| bias_en | output | 1 | Bias block enable |
| clk_drv_en | output | 1 | Clock-lane driver enable |
| data_drv_en | output | 4 | Per-lane data driver enables |

## Verification
The hardest situation to reach is the second bring-up. Only there do the retained analog enables from an earlier bring-up get cleared at the regulator step. It needs a full bring-up, a teardown and a new bring-up with the other pixel depth. The stimulus also reaches two cases where the request flips while `seq_busy` is high: during the timed waits, and inside the two-cycle teardown. An immediate restart from the off state then follows. A behavioural reference model that is stepped every clock predicts each edge, including the exact wait lengths.

// File: rtl/lvds_seq_pkg.sv
package lvds_seq_pkg;
    localparam int TRIM_W    = 3;
    localparam int NUM_LANES = 4;
    localparam int LANES_18  = 3;

    localparam logic [TRIM_W-1:0] CUR_TRIM_VAL  = 3'd2;
    localparam logic [TRIM_W-1:0] VOLT_TRIM_VAL = 3'd3;
    localparam logic [TRIM_W-1:0] PDRV_TRIM_VAL = 3'd2;

    typedef enum logic [2:0] {
        IDLE_OFF,
        GLB_UP,
        IF_UP,
        LDO_WAIT,
        BIAS_WAIT,
        CLKDRV_UP,
        LINK_ON,
        IF_DOWN
    } seq_state_t;
endpackage

// File: rtl/lvds_seq_timer.sv
module lvds_seq_timer #(
    parameter int WAIT_CYC = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);
    localparam int CW = $clog2(WAIT_CYC + 1);
    localparam logic [CW-1:0] LOADV = CW'(WAIT_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= LOADV;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // expiry one cycle before zero: the consumer acts on the edge that
    // completes WAIT_CYC cycles since the load edge
    assign expire = (cnt == CW'(1));

    p_expire_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !start) |=> !expire);
endmodule

// File: rtl/lvds_lane_mask.sv
module lvds_lane_mask
    import lvds_seq_pkg::*;
(
    input  logic                 depth18,
    output logic [NUM_LANES-1:0] mask
);
    localparam int LANES18 = LANES_18;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        if (i < LANES18) begin : g_always
            assign mask[i] = 1'b1;
        end else begin : g_wide
            assign mask[i] = ~depth18;
        end
    end
endmodule

// File: rtl/lvds_pwr_seq.sv
module lvds_pwr_seq
    import lvds_seq_pkg::*;
#(
    parameter int CLK_PER_US = 200
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 link_req,
    input  logic                 depth18,
    output logic                 seq_busy,
    output logic                 seq_done,
    output logic                 glb_en,
    output logic                 link_if_en,
    output logic                 ldo_en,
    output logic [TRIM_W-1:0]    cur_trim,
    output logic [TRIM_W-1:0]    volt_trim,
    output logic [TRIM_W-1:0]    pdrv_trim,
    output logic                 bias_en,
    output logic                 clk_drv_en,
    output logic [NUM_LANES-1:0] data_drv_en
);
    localparam int WAIT_CYC = 2 * CLK_PER_US;

    seq_state_t           state, nxt;
    logic                 tmr_start, tmr_expire;
    logic [NUM_LANES-1:0] lane_mask;

    lvds_seq_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .expire (tmr_expire)
    );

    lvds_lane_mask u_mask (
        .depth18 (depth18),
        .mask    (lane_mask)
    );

    assign tmr_start = (state == IF_UP) || (state == LDO_WAIT && tmr_expire);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IDLE_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            IDLE_OFF:  if (link_req)   nxt = GLB_UP;
            GLB_UP:                    nxt = IF_UP;
            IF_UP:                     nxt = LDO_WAIT;
            LDO_WAIT:  if (tmr_expire) nxt = BIAS_WAIT;
            BIAS_WAIT: if (tmr_expire) nxt = CLKDRV_UP;
            CLKDRV_UP:                 nxt = LINK_ON;
            LINK_ON:   if (!link_req)  nxt = IF_DOWN;
            IF_DOWN:                   nxt = IDLE_OFF;
            default:                   nxt = IDLE_OFF;
        endcase
    end

    // outputs: each state has one predecessor, so the entry action is
    // applied on the edge that enters it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_busy    <= 1'b0;
            seq_done    <= 1'b0;
            glb_en      <= 1'b0;
            link_if_en  <= 1'b0;
            ldo_en      <= 1'b0;
            cur_trim    <= '0;
            volt_trim   <= '0;
            pdrv_trim   <= '0;
            bias_en     <= 1'b0;
            clk_drv_en  <= 1'b0;
            data_drv_en <= '0;
        end else begin
            seq_done <= 1'b0;
            if (nxt != state) begin
                unique case (nxt)
                    GLB_UP: begin
                        glb_en   <= 1'b1;
                        seq_busy <= 1'b1;
                    end
                    IF_UP:     link_if_en <= 1'b1;
                    LDO_WAIT: begin
                        ldo_en      <= 1'b1;
                        cur_trim    <= CUR_TRIM_VAL;
                        volt_trim   <= VOLT_TRIM_VAL;
                        pdrv_trim   <= PDRV_TRIM_VAL;
                        bias_en     <= 1'b0;
                        clk_drv_en  <= 1'b0;
                        data_drv_en <= '0;
                    end
                    BIAS_WAIT: bias_en    <= 1'b1;
                    CLKDRV_UP: clk_drv_en <= 1'b1;
                    LINK_ON: begin
                        data_drv_en <= lane_mask;
                        seq_done    <= 1'b1;
                        seq_busy    <= 1'b0;
                    end
                    IF_DOWN: begin
                        link_if_en <= 1'b0;
                        seq_busy   <= 1'b1;
                    end
                    IDLE_OFF: begin
                        glb_en   <= 1'b0;
                        seq_done <= 1'b1;
                        seq_busy <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    p_if_needs_glb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        link_if_en |-> glb_en);
    p_bias_needs_ldo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bias_en) |-> ldo_en);
    p_clk_needs_bias_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_drv_en) |-> bias_en);
    p_lane_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_drv_en != '0) |-> (data_drv_en == 4'b0111 || data_drv_en == 4'b1111));
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);
    p_done_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !seq_busy);
    p_glb_after_if_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(glb_en) |-> (!link_if_en && $past(!link_if_en)));
endmodule

// File: tb/lvds_pwr_seq_tb_top.sv
module lvds_pwr_seq_tb_top;
    localparam int CPU = 4;
    localparam int W   = 2 * CPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_req = 1'b0;
    logic depth18 = 1'b0;
    logic seq_busy, seq_done, glb_en, link_if_en, ldo_en, bias_en, clk_drv_en;
    logic [2:0] cur_trim, volt_trim, pdrv_trim;
    logic [3:0] data_drv_en;

    always #2.5 clk = ~clk;

    lvds_pwr_seq #(.CLK_PER_US(CPU)) dut_i (
        .clk(clk), .rst_n(rst_n), .link_req(link_req), .depth18(depth18),
        .seq_busy(seq_busy), .seq_done(seq_done), .glb_en(glb_en),
        .link_if_en(link_if_en), .ldo_en(ldo_en), .cur_trim(cur_trim),
        .volt_trim(volt_trim), .pdrv_trim(pdrv_trim), .bias_en(bias_en),
        .clk_drv_en(clk_drv_en), .data_drv_en(data_drv_en)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 0;
    string scen = "R1";

    // behavioural reference model
    logic m_busy = 0, m_done = 0, m_glb = 0, m_if = 0, m_ldo = 0, m_bias = 0, m_clkd = 0;
    logic [2:0] m_cur = 0, m_volt = 0, m_pdrv = 0;
    logic [3:0] m_data = 0;
    bit m_on = 0;

    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            m_done = 0;
            if (!m_on && link_req) begin
                m_glb = 1; m_busy = 1;
                @(posedge clk); m_if = 1;
                @(posedge clk);
                m_ldo = 1; m_cur = 2; m_volt = 3; m_pdrv = 2;
                m_bias = 0; m_clkd = 0; m_data = 0;
                repeat (W) @(posedge clk);
                m_bias = 1;
                repeat (W) @(posedge clk);
                m_clkd = 1;
                @(posedge clk);
                m_data = depth18 ? 4'b0111 : 4'b1111;
                m_done = 1; m_busy = 0; m_on = 1;
            end else if (m_on && !link_req) begin
                m_if = 0; m_busy = 1;
                @(posedge clk);
                m_glb = 0; m_done = 1; m_busy = 0; m_on = 0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] act=%0d exp=%0d t=%0t", tag, scen, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (cmp_on) begin
        chk("R2 R7 glb_en", glb_en, m_glb);
        chk("R2 R7 link_if_en", link_if_en, m_if);
        chk("R2 R8 ldo_en", ldo_en, m_ldo);
        chk("R2 R8 cur_trim", cur_trim, m_cur);
        chk("R2 R8 volt_trim", volt_trim, m_volt);
        chk("R2 R8 pdrv_trim", pdrv_trim, m_pdrv);
        chk("R3 R9 bias_en", bias_en, m_bias);
        chk("R4 R9 clk_drv_en", clk_drv_en, m_clkd);
        chk("R5 R9 data_drv_en", data_drv_en, m_data);
        chk("R6 seq_busy", seq_busy, m_busy);
        chk("R6 seq_done", seq_done, m_done);
    end

    task automatic wait_done();
        for (int i = 0; i < 4 * W + 20; i++) begin
            @(negedge clk);
            if (seq_done) return;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values at the ports
        chk("R1 reset outputs", {seq_busy, seq_done, glb_en, link_if_en, ldo_en,
            bias_en, clk_drv_en, data_drv_en, cur_trim, volt_trim, pdrv_trim}, 0);
        rst_n = 1'b1;
        cmp_on = 1;
        scen = "R11 off idle";
        idle(5);
        // 24-bit bring-up; request wobbles during the waits (R10)
        scen = "R10 R5 24bit up";
        link_req = 1; depth18 = 0;
        idle(6);
        link_req = 0; idle(3);
        link_req = 1;
        wait_done();
        chk("R5 four lanes", data_drv_en, 4'b1111);
        scen = "R11 on hold";
        idle(8);
        // teardown, request returns inside it (R10, R7, R8)
        scen = "R7 R8 R10 teardown";
        link_req = 0;
        idle(1);
        link_req = 1; depth18 = 1;
        wait_done();
        chk("R8 analog retained", {ldo_en, bias_en, clk_drv_en, data_drv_en}, 7'b1111111);
        // restart from off with 18-bit: retained enables cleared (R9)
        scen = "R9 R5 18bit up";
        wait_done();
        chk("R5 three lanes", data_drv_en, 4'b0111);
        // drop request during bring-up: teardown right after completion
        scen = "R10 R7 drop";
        link_req = 0; idle(4);
        link_req = 1; idle(3);
        link_req = 0; depth18 = 0;
        wait_done();
        wait_done();
        chk("R7 off after drop", {glb_en, link_if_en}, 0);
        scen = "R11 off idle2";
        idle(10);
        cmp_on = 0;
        finish_run();
    end
endmodule